// File: doc/BRIEF.md
# T1/E1 Transmit Pattern Generator

This block sits on the transmit data path of a T1/E1 line interface and decides, one bit per transmit clock, what goes onto the line. The bit can come from one of five sources:

- the user's serial data;
- a forced unframed all-ones stream;
- a 1,0 alternating stream;
- a pseudo-random sequence whose length depends on the E1/T1 mode;
- a short programmable loop-up code repeated without framing.

On top of the chosen stream, software can inject one bit error or one bipolar violation per request. A bipolar violation is deferred until the transmitted stream next carries three ones in a row.

All-ones is the state the block comes out of reset in, because the transmit-enable bit is cleared by reset. All-ones can also be forced automatically by receive-side carrier-loss or all-ones alarms. The selected bit feeds an AMI encoder, which drives the positive and negative rail pulses toward the line driver.

Top module: `t1e1_tx_patgen`

## Requirements
- R1: While `tx_enable` is 0, which is also its value after reset, every transmitted bit is a one (a mark on one rail).
- R2: With `tx_enable`=1 and `auto_ones_en`=1, every transmitted bit is a one while `carrier_loss` or `rx_all_ones` is 1. With `auto_ones_en`=0 those two flags have no effect.
- R3: The alternating source sends 1,0,1,0,... It sends 1 on the first cycle it is selected after reset, and it advances only on cycles where it is selected.
- R4: The PRBS source is a 20-bit shift register, set to all ones by reset, that shifts left by one on each selected cycle. In E1 mode (`e1_mode`=1) it outputs bit 14 and feeds back bit14 XOR bit13 (2^15-1). In T1 mode it outputs bit 19 and feeds back bit19 XOR bit16 (2^20-1).
- R5: The loop-code source sends `loop_code[loop_len]` down to `loop_code[0]`, most significant bit first, so the word is `loop_len`+1 bits long. It repeats with no framing, and the first selected bit after reset is `loop_code[loop_len]`.
- R6: Source priority, from highest to lowest, is forced all ones (R1/R2), alternating, PRBS, loop code, then `data_in`.
- R7: On a cycle where `err_req` is 1 after being 0 on the previous cycle, the transmitted bit is inverted. Holding `err_req` high causes no further errors.
- R8: A 0-to-1 change of `bpv_req` arms a one-shot. Starting the cycle after that change, the block counts consecutive transmitted ones, and the third of them is sent with the same polarity as the mark before it. A new 0-to-1 change while the one-shot is armed is ignored.
- R9: A zero drives both rails low. Marks alternate polarity, and the first mark after reset is positive. After a violation, alternation resumes from the violating mark. `tx_pos` and `tx_neg` are never both 1.
- R10: Outputs are registered. The bit chosen from the inputs of cycle n appears on the rails after clock edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 1 = E1 PRBS length, 0 = T1 |
| tx_enable | input | 1 | 0 forces all ones; cleared state is the default |
| auto_ones_en | input | 1 | Enables all ones on receive alarms |
| carrier_loss | input | 1 | Receive carrier-loss alarm |
| rx_all_ones | input | 1 | Receive all-ones alarm |
| alt_en | input | 1 | Select alternating 1,0 source |
| prbs_en | input | 1 | Select PRBS source |
| loop_en | input | 1 | Select loop-code source |
| loop_code | input | CODE_W | Loop-up code word |
| loop_len | input | LEN_W | Code length minus one |
| data_in | input | 1 | User transmit data |
| err_req | input | 1 | Single bit-error request (rising edge) |
| bpv_req | input | 1 | Single bipolar-violation request (rising edge) |
| tx_pos | output | 1 | Positive rail pulse |
| tx_neg | output | 1 | Negative rail pulse |

## Verification
The hardest situation to reach is a violation request that is already armed, meets a second request, and is then kept waiting by a run of ones broken by a zero. Only a fresh run of three ones may fire it, and it may fire only once. The bench reaches this state by driving user data bit by bit. It raises the request on a zero, re-raises it while armed, and breaks the first run with a zero. It then compares every rail against a bench-side model of polarity, arming and run length.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // Source selected for the current bit
    typedef enum logic [2:0] {
        SRC_ONES = 3'd0,
        SRC_ALT  = 3'd1,
        SRC_PRBS = 3'd2,
        SRC_LOOP = 3'd3,
        SRC_DATA = 3'd4
    } src_e;

    // One line symbol on the two rails
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam int PRBS_W   = 20;
    localparam int E1_TAP_A = 14;
    localparam int E1_TAP_B = 13;
    localparam int T1_TAP_A = 19;
    localparam int T1_TAP_B = 16;

    function automatic logic prbs_out(input logic [PRBS_W-1:0] s, input logic e1);
        return e1 ? s[E1_TAP_A] : s[T1_TAP_A];
    endfunction

    function automatic logic [PRBS_W-1:0] prbs_next(input logic [PRBS_W-1:0] s,
                                                    input logic e1);
        logic fb;
        fb = e1 ? (s[E1_TAP_A] ^ s[E1_TAP_B]) : (s[T1_TAP_A] ^ s[T1_TAP_B]);
        return {s[PRBS_W-2:0], fb};
    endfunction

endpackage

// File: rtl/tpg_edge.sv
module tpg_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // During reset the history tracks the request so no edge is seen at release
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= req[i];
            else     prev_q[i] <= req[i];
        end
        assign rise[i] = req[i] & ~prev_q[i];
    end
endmodule

// File: rtl/tpg_source.sv
module tpg_source
    import tpg_pkg::*;
#(
    parameter  int CODE_W = 8,
    localparam int LEN_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              e1_mode,
    input  logic              tx_enable,
    input  logic              auto_ones_en,
    input  logic              carrier_loss,
    input  logic              rx_all_ones,
    input  logic              alt_en,
    input  logic              prbs_en,
    input  logic              loop_en,
    input  logic [CODE_W-1:0] loop_code,
    input  logic [LEN_W-1:0]  loop_len,
    input  logic              data_in,
    output logic              bit_o
);
    src_e              sel;
    logic              alarm;
    logic              alt_q;
    logic [PRBS_W-1:0] lfsr_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  idx;

    assign alarm = auto_ones_en & (carrier_loss | rx_all_ones);
    assign idx   = loop_len - cnt_q;

    always_comb begin
        if (!tx_enable || alarm) sel = SRC_ONES;
        else if (alt_en)         sel = SRC_ALT;
        else if (prbs_en)        sel = SRC_PRBS;
        else if (loop_en)        sel = SRC_LOOP;
        else                     sel = SRC_DATA;
    end

    always_comb begin
        unique case (sel)
            SRC_ONES: bit_o = 1'b1;
            SRC_ALT:  bit_o = alt_q;
            SRC_PRBS: bit_o = prbs_out(lfsr_q, e1_mode);
            SRC_LOOP: bit_o = loop_code[idx];
            default:  bit_o = data_in;
        endcase
    end

    // Each generator advances only while it drives the line
    always_ff @(posedge clk) begin
        if (rst) begin
            alt_q  <= 1'b1;
            lfsr_q <= '1;
            cnt_q  <= '0;
        end else begin
            unique case (sel)
                SRC_ALT:  alt_q  <= ~alt_q;
                SRC_PRBS: lfsr_q <= prbs_next(lfsr_q, e1_mode);
                SRC_LOOP: cnt_q  <= (cnt_q >= loop_len) ? '0 : cnt_q + 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tpg_ami.sv
module tpg_ami
    import tpg_pkg::*;
#(
    parameter  int RUN_LEN = 3,
    localparam int RUN_W   = $clog2(RUN_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    input  logic bpv_pulse,
    output logic tx_pos,
    output logic tx_neg
);
    rail_t            rail_q;
    logic             last_pos_q;
    logic             armed_q;
    logic [RUN_W-1:0] run_q;
    logic             viol;
    logic             pol;

    // Violation fires on the last one of the run while armed
    assign viol = armed_q & bit_i & (run_q == RUN_W'(RUN_LEN - 1));
    assign pol  = viol ? last_pos_q : ~last_pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rail_q     <= '0;
            last_pos_q <= 1'b0;
        end else if (bit_i) begin
            rail_q.pos <= pol;
            rail_q.neg <= ~pol;
            last_pos_q <= pol;
        end else begin
            rail_q     <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            run_q   <= '0;
        end else if (armed_q) begin
            if (viol) begin
                armed_q <= 1'b0;
                run_q   <= '0;
            end else begin
                run_q   <= bit_i ? run_q + 1'b1 : '0;
            end
        end else if (bpv_pulse) begin
            armed_q <= 1'b1;
            run_q   <= '0;
        end
    end

    assign tx_pos = rail_q.pos;
    assign tx_neg = rail_q.neg;
endmodule

// File: rtl/t1e1_tx_patgen.sv
module t1e1_tx_patgen
    import tpg_pkg::*;
#(
    parameter  int CODE_W  = 8,
    parameter  int RUN_LEN = 3,
    localparam int LEN_W   = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              e1_mode,
    input  logic              tx_enable,
    input  logic              auto_ones_en,
    input  logic              carrier_loss,
    input  logic              rx_all_ones,
    input  logic              alt_en,
    input  logic              prbs_en,
    input  logic              loop_en,
    input  logic [CODE_W-1:0] loop_code,
    input  logic [LEN_W-1:0]  loop_len,
    input  logic              data_in,
    input  logic              err_req,
    input  logic              bpv_req,
    output logic              tx_pos,
    output logic              tx_neg
);
    localparam int REQ_N = 2;

    logic [REQ_N-1:0] req_rise;
    logic             src_bit;
    logic             line_bit;

    tpg_edge #(.N(REQ_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .req  ({bpv_req, err_req}),
        .rise (req_rise)
    );

    tpg_source #(.CODE_W(CODE_W)) u_src (
        .clk          (clk),
        .rst          (rst),
        .e1_mode      (e1_mode),
        .tx_enable    (tx_enable),
        .auto_ones_en (auto_ones_en),
        .carrier_loss (carrier_loss),
        .rx_all_ones  (rx_all_ones),
        .alt_en       (alt_en),
        .prbs_en      (prbs_en),
        .loop_en      (loop_en),
        .loop_code    (loop_code),
        .loop_len     (loop_len),
        .data_in      (data_in),
        .bit_o        (src_bit)
    );

    // Single bit error applied to whichever source is on the line
    assign line_bit = src_bit ^ req_rise[0];

    tpg_ami #(.RUN_LEN(RUN_LEN)) u_ami (
        .clk       (clk),
        .rst       (rst),
        .bit_i     (line_bit),
        .bpv_pulse (req_rise[1]),
        .tx_pos    (tx_pos),
        .tx_neg    (tx_neg)
    );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker (
    input logic clk,
    input logic rst,
    input logic tx_enable,
    input logic auto_ones_en,
    input logic carrier_loss,
    input logic rx_all_ones,
    input logic alt_en,
    input logic err_req,
    input logic bpv_req,
    input logic tx_pos,
    input logic tx_neg
);
    logic err_prev, bpv_prev, err_rise, bpv_rise;
    logic alarm, alt_ok, alt_ok_q;
    logic seen_q, last_q, allow_q, mark, viol_seen;

    assign err_rise  = err_req & ~err_prev;
    assign bpv_rise  = bpv_req & ~bpv_prev;
    assign alarm     = auto_ones_en & (carrier_loss | rx_all_ones);
    assign alt_ok    = tx_enable & ~alarm & alt_en & ~err_rise;
    assign mark      = tx_pos | tx_neg;
    assign viol_seen = mark & seen_q & (tx_pos == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_prev <= err_req;
            bpv_prev <= bpv_req;
            alt_ok_q <= 1'b0;
            seen_q   <= 1'b0;
            last_q   <= 1'b0;
            allow_q  <= 1'b0;
        end else begin
            err_prev <= err_req;
            bpv_prev <= bpv_req;
            alt_ok_q <= alt_ok;
            if (mark) begin
                seen_q <= 1'b1;
                last_q <= tx_pos;
            end
            if (viol_seen)     allow_q <= 1'b0;
            else if (bpv_rise) allow_q <= 1'b1;
        end
    end

    // R9: rails exclusive
    p_rails_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(tx_pos && tx_neg));

    // R1: transmit disabled gives a mark on the next cycle
    p_forced_ones_r1: assert property (@(posedge clk) disable iff (rst)
        (!tx_enable && !err_rise) |=> (tx_pos || tx_neg));

    // R2: alarm-driven all ones
    p_alarm_ones_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_enable && alarm && !err_rise) |=> (tx_pos || tx_neg));

    // R3: alternating source changes value every selected cycle
    p_alt_toggles_r3: assert property (@(posedge clk) disable iff (rst)
        (alt_ok && alt_ok_q) |=> ((tx_pos || tx_neg) != $past(tx_pos || tx_neg)));

    // R8: a same-polarity mark only after a violation request
    p_bpv_requested_r8: assert property (@(posedge clk) disable iff (rst)
        viol_seen |-> allow_q);
endmodule

bind t1e1_tx_patgen tpg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_enable    (tx_enable),
    .auto_ones_en (auto_ones_en),
    .carrier_loss (carrier_loss),
    .rx_all_ones  (rx_all_ones),
    .alt_en       (alt_en),
    .err_req      (err_req),
    .bpv_req      (bpv_req),
    .tx_pos       (tx_pos),
    .tx_neg       (tx_neg)
);

// File: tb/t1e1_tx_patgen_test.sv
module t1e1_tx_patgen_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       e1_mode, tx_enable, auto_ones_en, carrier_loss, rx_all_ones;
    logic       alt_en, prbs_en, loop_en, data_in, err_req, bpv_req;
    logic [7:0] loop_code;
    logic [2:0] loop_len;
    logic       tx_pos, tx_neg;

    int checks = 0;
    int fails  = 0;

    // bench-side line model for user-data tests
    logic       m_last_pos, m_armed, m_err_prev, m_bpv_prev;
    int         m_run;
    logic [19:0] m_lfsr;

    always #5 clk = ~clk;

    t1e1_tx_patgen uut (
        .clk(clk), .rst(rst), .e1_mode(e1_mode), .tx_enable(tx_enable),
        .auto_ones_en(auto_ones_en), .carrier_loss(carrier_loss),
        .rx_all_ones(rx_all_ones), .alt_en(alt_en), .prbs_en(prbs_en),
        .loop_en(loop_en), .loop_code(loop_code), .loop_len(loop_len),
        .data_in(data_in), .err_req(err_req), .bpv_req(bpv_req),
        .tx_pos(tx_pos), .tx_neg(tx_neg)
    );

    // {tx_enable, auto, carrier_loss, rx_all_ones, alt, prbs, loop, data, expected mark}
    localparam logic [8:0] VEC [10] = '{
        9'b0_0_0_0_0_0_0_0_1,
        9'b0_0_0_0_1_0_0_0_1,
        9'b1_1_1_0_0_0_0_0_1,
        9'b1_1_0_1_0_1_0_0_1,
        9'b1_0_1_0_0_0_0_0_0,
        9'b1_0_0_1_0_0_0_1_1,
        9'b1_0_0_0_0_0_0_0_0,
        9'b1_0_0_0_0_0_0_1_1,
        9'b1_1_0_0_0_0_0_0_0,
        9'b0_1_1_0_0_0_1_0_1
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rails actual %b expected %b", req, act, exp);
        end
    endtask

    // one bit time: drive at falling edge, sample just after rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_last_pos = 1'b0; m_armed = 1'b0; m_run = 0;
        m_err_prev = err_req; m_bpv_prev = bpv_req;
        m_lfsr = '1;
    endtask

    // expect a bit value (mark presence only)
    task automatic expect_bit(input string req, input logic b);
        tick();
        check(req, {1'b0, tx_pos | tx_neg}, {1'b0, b});
        check("R9", {tx_pos, tx_neg} == 2'b11 ? 2'b11 : 2'b00, 2'b00);
    endtask

    // user data bit with error/violation requests, full polarity model
    task automatic step(input string req, input logic d, input logic e, input logic b);
        logic bitv, viol, pol;
        logic [1:0] exp;
        @(negedge clk);
        data_in = d; err_req = e; bpv_req = b;
        bitv = d ^ (e & ~m_err_prev);
        viol = m_armed & bitv & (m_run == 2);
        pol  = viol ? m_last_pos : ~m_last_pos;
        exp  = bitv ? {pol, ~pol} : 2'b00;
        if (bitv) m_last_pos = pol;
        if (m_armed) begin
            if (viol) begin m_armed = 1'b0; m_run = 0; end
            else m_run = bitv ? m_run + 1 : 0;
        end else if (b & ~m_bpv_prev) begin
            m_armed = 1'b1; m_run = 0;
        end
        m_err_prev = e; m_bpv_prev = b;
        tick();
        check(req, {tx_pos, tx_neg}, exp);
    endtask

    function automatic logic [19:0] model_next(input logic [19:0] s, input logic e1);
        logic fb;
        fb = e1 ? (s[14] ^ s[13]) : (s[19] ^ s[16]);
        return {s[18:0], fb};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        e1_mode = 1'b1; tx_enable = 1'b0; auto_ones_en = 1'b0;
        carrier_loss = 1'b0; rx_all_ones = 1'b0; alt_en = 1'b0;
        prbs_en = 1'b0; loop_en = 1'b0; data_in = 1'b0;
        err_req = 1'b0; bpv_req = 1'b0; loop_code = 8'h0B; loop_len = 3'd3;
        do_reset();
        #1;
        check("R10 reset rails low", {tx_pos, tx_neg}, 2'b00);
        // R1: default after reset is all ones, first mark positive (R9)
        tick();
        check("R1 default ones, R9 first mark positive", {tx_pos, tx_neg}, 2'b10);

        // R1/R2/R6 priority table
        foreach (VEC[i]) begin
            @(negedge clk);
            {tx_enable, auto_ones_en, carrier_loss, rx_all_ones,
             alt_en, prbs_en, loop_en, data_in} = VEC[i][8:1];
            expect_bit("R1/R2/R6 table", VEC[i][0]);
        end

        // R3 alternating, first selection after reset gives 1; R6 alt over prbs
        @(negedge clk);
        tx_enable = 1'b1; auto_ones_en = 1'b0; carrier_loss = 1'b0; rx_all_ones = 1'b0;
        alt_en = 1'b1; prbs_en = 1'b0; loop_en = 1'b0; data_in = 1'b0;
        for (int k = 0; k < 4; k++) expect_bit("R3 alternating", (k % 2) == 0);
        @(negedge clk);
        prbs_en = 1'b1;
        for (int k = 0; k < 4; k++) expect_bit("R6 alt above prbs", (k % 2) == 0);

        // R4 PRBS E1 then T1, continuing from the same register
        @(negedge clk);
        alt_en = 1'b0; e1_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            expect_bit("R4 prbs e1", m_lfsr[14]);
            m_lfsr = model_next(m_lfsr, 1'b1);
        end
        @(negedge clk);
        e1_mode = 1'b0;
        for (int k = 0; k < 40; k++) begin
            expect_bit("R4 prbs t1", m_lfsr[19]);
            m_lfsr = model_next(m_lfsr, 1'b0);
        end

        // R5 loop code 4 bits 1011, then 8 bits 11001010; R6 prbs above loop
        @(negedge clk);
        prbs_en = 1'b0; loop_en = 1'b1; loop_code = 8'h0B; loop_len = 3'd3;
        for (int k = 0; k < 12; k++) expect_bit("R5 loop 4-bit", loop_code[3 - (k % 4)]);
        @(negedge clk);
        loop_code = 8'hCA; loop_len = 3'd7;
        for (int k = 0; k < 8; k++) expect_bit("R5 loop 8-bit", loop_code[7 - k]);
        @(negedge clk);
        prbs_en = 1'b1; e1_mode = 1'b1;
        expect_bit("R6 prbs above loop", m_lfsr[14]);

        // fresh reset for the polarity-exact user data tests
        @(negedge clk);
        prbs_en = 1'b0; loop_en = 1'b0; tx_enable = 1'b1;
        do_reset();
        // R9 AMI alternation
        step("R9 ami", 1, 0, 0);
        step("R9 ami zero", 0, 0, 0);
        step("R9 ami", 1, 0, 0);
        step("R9 ami", 1, 0, 0);
        // R7 single bit error, held high gives no more
        step("R7 error on zero", 0, 1, 0);
        step("R7 held no error", 0, 1, 0);
        step("R7 no error", 1, 0, 0);
        step("R7 error on one", 1, 1, 0);
        step("R7 held no error", 1, 1, 0);
        step("R7 release", 0, 0, 0);
        // R8 armed BPV, re-request ignored, run broken, then violation once
        step("R8 arm", 0, 0, 1);
        step("R8 one", 1, 0, 0);
        step("R8 re-request ignored", 1, 0, 1);
        step("R8 run broken", 0, 0, 0);
        step("R8 run 1", 1, 0, 0);
        step("R8 run 2", 1, 0, 0);
        step("R8 violation", 1, 0, 0);
        step("R8 after violation", 1, 0, 0);
        step("R8 after violation", 1, 0, 0);
        step("R8 no second violation", 1, 0, 0);
        step("R8 idle", 0, 0, 0);
        // R2 alarm ignored when automatic mode off, honoured when on
        @(negedge clk);
        data_in = 1'b0; carrier_loss = 1'b1;
        expect_bit("R2 alarm ignored", 1'b0);
        @(negedge clk);
        auto_ones_en = 1'b1;
        expect_bit("R2 carrier loss ones", 1'b1);
        @(negedge clk);
        carrier_loss = 1'b0; rx_all_ones = 1'b1;
        expect_bit("R2 rx all ones", 1'b1);
        @(negedge clk);
        rx_all_ones = 1'b0;
        expect_bit("R2 alarm cleared", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule